// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Storage Register

The block accepts a serial bit stream into a shift register and, on request, copies the whole shift register into a separate storage register. The storage register drives the parallel outputs. A serial output carries the lowest bit of the shift register, so several copies can be chained into one longer word. Two active-low controls choose what the shift register does: shift in new data, load the stored word back, or keep its value. The same two controls also decide whether the storage register may capture.

Everything runs on a single clock, `clk`. Two strobes, `shift_en` and `store_en`, mark the cycles in which a shift-clock or storage-clock event takes place. If both strobes are high in the same cycle, the storage register takes the shift register value from before that cycle's shift. This gives the required ordering between the two clocks a fixed, defined outcome. Reset is synchronous and active high.

Top module: `sipo_store_reg`

## Requirements
- R1: When `rst` is high at a rising `clk` edge, both the shift register and the storage register become zero. `par_out` and `sdo` therefore read 0 after that edge.
- R2: When `sel_n`=0, `wr_n`=0 and `shift_en`=1, the shift register moves right by one bit at the edge. `sdi` enters bit WIDTH-1 (the MSB) and every bit i takes the old value of bit i+1.
- R3: `sdo` always shows bit 0 (the LSB) of the shift register. A bit shifted in therefore appears on `sdo` after WIDTH shifts.
- R4: When `sel_n`=0, `wr_n`=1 and `shift_en`=1, the shift register loads the storage register contents at the edge.
- R5: When `sel_n`=1, the shift register keeps its value whatever `shift_en`, `wr_n` and `sdi` do.
- R6: When `shift_en`=0, the shift register keeps its value.
- R7: When `store_en`=1 with `sel_n`=0 and `wr_n`=0, the storage register takes the shift register value from before the edge, even if a shift happens in the same cycle.
- R8: The storage register keeps its value when `sel_n`=1, when `wr_n`=1, or when `store_en`=0.
- R9: `par_out` always equals the storage register. A run of shifts without a capture leaves `par_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select; high freezes both registers |
| wr_n | input | 1 | Active-low write; high selects load-back and blocks capture |
| shift_en | input | 1 | Shift-event strobe |
| store_en | input | 1 | Storage-capture strobe |
| sdi | input | 1 | Serial data in, enters the MSB |
| sdo | output | 1 | Serial data out, the LSB of the shift register |
| par_out | output | WIDTH | Storage register contents |

## Verification
Assertions check these rules on every cycle:
- the hold cases of both registers;
- the MSB entry and bit movement of a shift;
- load-back of the stored word;
- capture of the pre-edge value;
- that `par_out` stays steady when nothing is captured;
- the reset result.

Some behaviour is only visible across a sequence of operations, so only the bench scenarios can show it. This covers a bit taking WIDTH shifts to reach `sdo`, a word surviving a capture followed by a load-back, and the outcome of every strobe and control mix when the bench model is applied cycle by cycle.

// File: rtl/sipo_store_pkg.sv
package sipo_store_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } sr_op_e;

endpackage

// File: rtl/sipo_mode_ctrl.sv
module sipo_mode_ctrl
  import sipo_store_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sel_n,
  input  logic   wr_n,
  input  logic   shift_en,
  input  logic   store_en,
  output sr_op_e sr_op,
  output logic   capture
);

  always_comb begin
    sr_op = OP_HOLD;
    if (!sel_n && shift_en) begin
      sr_op = wr_n ? OP_LOAD : OP_SHIFT;
    end
  end

  assign capture = store_en && !sel_n && !wr_n;

  // R7: a capture never coincides with a load-back
  assert_capture_excl_R7: assert property (@(posedge clk) disable iff (rst)
    capture |-> (sr_op != OP_LOAD));

  // R5: a deselected block issues no shift-register operation
  assert_deselect_hold_R5: assert property (@(posedge clk) disable iff (rst)
    sel_n |-> (sr_op == OP_HOLD && !capture));

endmodule

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage
  import sipo_store_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  sr_op_e           sr_op,
  input  logic             sdi,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] sr_q
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shifted;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    if (g == MSB) begin : g_top
      assign shifted[g] = sdi;
    end else begin : g_mid
      assign shifted[g] = sr_q[g+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else begin
      unique case (sr_op)
        OP_SHIFT: sr_q <= shifted;
        OP_LOAD:  sr_q <= load_val;
        default:  sr_q <= sr_q;
      endcase
    end
  end

  // R2: MSB takes the serial input, the rest move one place down
  assert_shift_right_R2: assert property (@(posedge clk) disable iff (rst)
    (sr_op == OP_SHIFT) |=>
      (sr_q[MSB] == $past(sdi)) && (sr_q[MSB-1:0] == $past(sr_q[MSB:1])));

  // R4: load-back copies the stored word
  assert_load_back_R4: assert property (@(posedge clk) disable iff (rst)
    (sr_op == OP_LOAD) |=> (sr_q == $past(load_val)));

  // R5 and R6: no operation, no change
  assert_sr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (sr_op == OP_HOLD) |=> $stable(sr_q));

  // R1: reset clears the shift register
  assert_sr_reset_R1: assert property (@(posedge clk)
    rst |=> (sr_q == '0));

endmodule

// File: rtl/sipo_store_stage.sv
module sipo_store_stage #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [WIDTH-1:0] sr_in,
  output logic [WIDTH-1:0] st_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (capture) begin
      st_q <= sr_in;
    end
  end

  // R7: capture takes the pre-edge shift register value
  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    capture |=> (st_q == $past(sr_in)));

  // R8: no capture, no change
  assert_store_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(st_q));

  // R1: reset clears the storage register
  assert_st_reset_R1: assert property (@(posedge clk)
    rst |=> (st_q == '0));

endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg
  import sipo_store_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic             shift_en,
  input  logic             store_en,
  input  logic             sdi,
  output logic             sdo,
  output logic [WIDTH-1:0] par_out
);

  sr_op_e           sr_op;
  logic             capture;
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] st_q;

  sipo_mode_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_n),
    .wr_n     (wr_n),
    .shift_en (shift_en),
    .store_en (store_en),
    .sr_op    (sr_op),
    .capture  (capture)
  );

  sipo_shift_stage #(.WIDTH(WIDTH)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .sr_op    (sr_op),
    .sdi      (sdi),
    .load_val (st_q),
    .sr_q     (sr_q)
  );

  sipo_store_stage #(.WIDTH(WIDTH)) store_i (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .sr_in   (sr_q),
    .st_q    (st_q)
  );

  assign sdo     = sr_q[0];
  assign par_out = st_q;

  // R9: a shift without a capture leaves the parallel outputs steady
  assert_par_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n && shift_en && !store_en) |=> $stable(par_out));

  // R3: after a shift the serial output shows the old bit 1
  assert_sdo_order_R3: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n && shift_en) |=> (sdo == $past(sr_q[1])));

endmodule

// File: tb/sipo_store_reg_tb.sv
module sipo_store_reg_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel_n = 1'b1;
  logic         wr_n = 1'b1;
  logic         shift_en = 1'b0;
  logic         store_en = 1'b0;
  logic         sdi = 1'b0;
  logic         sdo;
  logic [W-1:0] par_out;

  int           n_cmp = 0;
  int           n_bad = 0;
  logic [W-1:0] m_sr = '0;
  logic [W-1:0] m_st = '0;
  logic [31:0]  rng = 32'h1234_abcd;

  always #2 clk = ~clk;

  sipo_store_reg #(.WIDTH(W)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_n),
    .wr_n     (wr_n),
    .shift_en (shift_en),
    .store_en (store_en),
    .sdi      (sdi),
    .sdo      (sdo),
    .par_out  (par_out)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic step(bit s_n, bit w_n, bit sh, bit st, bit d);
    logic [W-1:0] old_sr;
    string        rq_sr;
    string        rq_st;
    @(negedge clk);
    sel_n = s_n; wr_n = w_n; shift_en = sh; store_en = st; sdi = d;
    @(posedge clk);
    #1;
    old_sr = m_sr;
    if (s_n)      rq_sr = "R5";
    else if (!sh) rq_sr = "R6";
    else if (w_n) rq_sr = "R4";
    else          rq_sr = "R2";
    if (!s_n && sh) m_sr = w_n ? m_st : {d, m_sr[W-1:1]};
    if (!s_n && !w_n && st) begin
      m_st = old_sr;
      rq_st = "R7";
    end else begin
      rq_st = "R8";
    end
    chk({rq_sr, "/R3 sdo"}, {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, m_sr[0]});
    chk({rq_st, "/R9 par_out"}, par_out, m_st);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    m_sr = '0;
    m_st = '0;
    chk("R1 par_out", par_out, '0);
    chk("R1 sdo", {{(W-1){1'b0}}, sdo}, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] word;
    logic [W-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 par_out after reset", par_out, '0);
    chk("R1 sdo after reset", {{(W-1){1'b0}}, sdo}, '0);
    @(negedge clk);
    rst = 1'b0;

    // R3/R9: shift a known word in, watch sdo order, par_out must stay 0
    word = 16'hA5C3;
    for (int i = 0; i < W; i++) begin
      step(0, 0, 1, 0, word[i]);
      chk("R9 par_out steady while shifting", par_out, '0);
    end
    // R7: capture the complete word
    step(0, 0, 0, 1, 0);
    chk("R7 captured word", par_out, word);
    // R3: bits leave in arrival order on sdo
    for (int i = 0; i < W; i++) begin
      chk("R3 sdo sequence", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, word[i]});
      step(0, 0, 1, 0, 1'b0);
    end
    // R4: load back the stored word and capture it again unchanged
    step(0, 1, 1, 0, 1'b1);
    step(0, 0, 0, 1, 1'b0);
    chk("R4 load-back round trip", par_out, word);
    // R7: same-cycle shift and capture stores the pre-shift value
    held = m_sr;
    step(0, 0, 1, 1, 1'b1);
    chk("R7 pre-shift capture", par_out, held);
    // R5/R8: deselected, nothing moves
    held = par_out;
    for (int i = 0; i < 8; i++) step(1, i[0], 1, 1, i[1]);
    chk("R8 deselect keeps storage", par_out, held);

    // exhaustive sweep over all control and strobe combinations
    for (int r = 0; r < 40; r++) begin
      for (int c = 0; c < 32; c++) begin
        rng = next_rng(rng);
        step(c[0], c[1], c[2], c[3], c[4] ^ rng[0]);
      end
    end

    do_reset();
    step(0, 0, 1, 1, 1'b1);
    step(0, 0, 0, 1, 1'b0);
    chk("R7 capture after reset", par_out, {1'b1, {(W-1){1'b0}}});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule